// File: doc/BRIEF.md
# Machine-Mode CSR Execute and Trap-Return Unit

This unit holds a small bank of machine-level control and status registers for a 32-bit core. It executes the six CSR instruction forms. Each form is a single read-modify-write: the value the register held before the instruction goes out on the write-back port in the same cycle. The new value is stored on the next rising clock edge.

The unit also executes the machine trap-return instruction. On that instruction it restores the interrupt-enable state in the status register and supplies the saved exception PC as a redirect target. Accesses that cannot be honoured raise an illegal-instruction flag with cause code 2 and leave all state untouched. Two cases cannot be honoured: an address with no register behind it, and a write to the read-only ISA register. A trap return attempted below machine privilege is also refused this way.

The decode stage drives the instruction fields and a valid strobe. Every output is combinational from these inputs and the stored registers.

Top module: `mcsr_exec`

## Requirements
- R1: After reset the machine status, scratch and exception-PC registers read 0, and the ISA register reads 0x40002000.
- R2: funct3 001 stores the rs1 register value, and funct3 101 stores the 5-bit rs1 field zero-extended; both always write.
- R3: funct3 010/110 store old OR operand, and funct3 011/111 store old AND NOT operand. The operand is the rs1 value for 010/011 and the zero-extended rs1 field for 110/111.
- R4: The immediate clear form clears exactly the bits set in the 5-bit field and leaves every other bit.
- R5: A legal CSR instruction drives the pre-update value on wb_data, with wb_en high and wb_rd equal to rd_idx, when rd_idx is non-zero. The stored update is seen by the next instruction. When rd_idx is zero, wb_en is low.
- R6: An address other than 0x300 (status), 0x301 (ISA), 0x340 (scratch) or 0x341 (exception PC) raises illegal_instr with exc_cause 2. It gives no write-back and changes no register.
- R7: Any write form aimed at 0x301 is illegal. A set or clear form with a zero rs1 field reads it legally.
- R8: A set or clear form (010, 011, 110, 111) with a zero rs1 field does not write the register.
- R9: In the status register only bit 3 (interrupt enable), bit 7 (previous enable) and bits 12:11 (previous privilege) are stored. All other bits read 0.
- R10: The trap-return instruction is funct3 000, funct7 0011000, rs2 00010. With cur_priv 11 it drives redirect_valid with redirect_pc equal to the exception PC. On the clock edge, bit 7 is copied into bit 3, bit 7 is set, and bits 12:11 are cleared.
- R11: The trap-return instruction with cur_priv below 11 raises illegal_instr with cause 2, gives no redirect and leaves the status register unchanged.
- R12: Writes to the exception-PC register force bit 0 to zero.
- R13: With instr_valid low, or with funct3 000 and any other funct7/rs2 pattern, all outputs stay at zero and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | A system-class instruction is present this cycle |
| funct3 | input | 3 | Operation selector |
| funct7 | input | 7 | Upper function field, used for trap-return decode |
| rs2_field | input | 5 | rs2 field, used for trap-return decode |
| rs1_field | input | 5 | rs1 index, or the immediate for forms 101/110/111 |
| rs1_value | input | 32 | Contents of the rs1 register |
| csr_addr | input | 12 | CSR address |
| rd_idx | input | 5 | Destination register index |
| cur_priv | input | 2 | Current privilege level (11 = machine) |
| wb_en | output | 1 | Write-back request |
| wb_rd | output | 5 | Write-back register index |
| wb_data | output | 32 | Pre-update CSR value |
| redirect_valid | output | 1 | Trap return taken |
| redirect_pc | output | 32 | Return target |
| illegal_instr | output | 1 | Illegal-instruction exception |
| exc_cause | output | 4 | Exception cause code (2 when illegal) |

## Verification
On every cycle the assertions check the following. An illegal instruction never writes back, writes or redirects. An idle or non-matching slot drives nothing. A zero-source set or clear never reaches the write port. Unused status bits stay zero, and the exception PC stays aligned. Each trap return leaves previous-enable set and previous-privilege cleared.

The bench scenarios are needed for the rest:
- the actual arithmetic of the six forms;
- the pre-update value returned while the new one appears only on the next instruction;
- reset values;
- the copy of the previous-enable bit into the enable bit on trap return.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
   localparam logic [11:0] ADDR_STATUS  = 12'h300;
   localparam logic [11:0] ADDR_ISA     = 12'h301;
   localparam logic [11:0] ADDR_SCRATCH = 12'h340;
   localparam logic [11:0] ADDR_EPC     = 12'h341;

   localparam int ST_IE      = 3;
   localparam int ST_PIE     = 7;
   localparam int ST_PPRV_LO = 11;

   localparam logic [6:0] RET_FUNCT7 = 7'b0011000;
   localparam logic [4:0] RET_RS2    = 5'b00010;
   localparam logic [1:0] PRIV_MACH  = 2'b11;
   localparam int         CAUSE_ILL  = 2;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;
endpackage

// File: rtl/mcsr_alu.sv
module mcsr_alu
   import mcsr_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 5
) (
   input  logic [2:0]      funct3,
   input  logic [IMM_W-1:0] rs1_field,
   input  logic [XLEN-1:0] rs1_value,
   input  logic [XLEN-1:0] old_val,
   output logic [XLEN-1:0] new_val,
   output logic            wr_req,
   output logic            op_known
);
   logic [XLEN-1:0] operand;
   csr_op_e         op;

   always_comb begin
      operand = funct3[2] ? {{(XLEN-IMM_W){1'b0}}, rs1_field} : rs1_value;
      op      = csr_op_e'(funct3[1:0]);
      op_known = (op != OP_NONE);
      unique case (op)
         OP_WRITE: new_val = operand;
         OP_SET:   new_val = old_val | operand;
         OP_CLEAR: new_val = old_val & ~operand;
         default:  new_val = old_val;
      endcase
      wr_req = (op == OP_WRITE) ||
               (((op == OP_SET) || (op == OP_CLEAR)) && (rs1_field != '0));
   end
endmodule

// File: rtl/mcsr_file.sv
module mcsr_file
   import mcsr_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter logic [31:0] ISA_RESET     = 32'h4000_2000,
   parameter logic [31:0] STATUS_WMASK  = 32'h0000_1888,
   parameter int          EPC_ZERO_LSBS = 1,
   parameter bit          SCRATCH_EN    = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [11:0]     addr,
   input  logic            we,
   input  logic [XLEN-1:0] wdata,
   input  logic            ret_en,
   output logic [XLEN-1:0] rdata,
   output logic            hit,
   output logic            read_only,
   output logic [XLEN-1:0] epc_out
);
   localparam logic [XLEN-1:0] ST_MASK  = XLEN'(STATUS_WMASK);
   localparam logic [XLEN-1:0] EPC_MASK = ~((XLEN'(1) << EPC_ZERO_LSBS) - XLEN'(1));

   if (XLEN != 32) begin : g_chk_xlen
      $error("mcsr_file: XLEN must be 32");
   end
   if (EPC_ZERO_LSBS < 0 || EPC_ZERO_LSBS > 2) begin : g_chk_epc
      $error("mcsr_file: EPC_ZERO_LSBS out of range");
   end

   logic [XLEN-1:0] status_q, epc_q, scratch_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
      end else if (ret_en) begin
         status_q[ST_IE]                  <= status_q[ST_PIE];
         status_q[ST_PIE]                 <= 1'b1;
         status_q[ST_PPRV_LO+1:ST_PPRV_LO] <= 2'b00;
      end else if (we && addr == ADDR_STATUS) begin
         status_q <= wdata & ST_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) epc_q <= '0;
      else if (we && addr == ADDR_EPC) epc_q <= wdata & EPC_MASK;
   end

   if (SCRATCH_EN) begin : g_scratch
      logic [XLEN-1:0] scratch_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) scratch_q <= '0;
         else if (we && addr == ADDR_SCRATCH) scratch_q <= wdata;
      end
      assign scratch_val = scratch_q;
   end else begin : g_no_scratch
      assign scratch_val = '0;
   end

   always_comb begin
      rdata     = '0;
      hit       = 1'b1;
      read_only = 1'b0;
      unique case (addr)
         ADDR_STATUS:  rdata = status_q;
         ADDR_ISA:     begin rdata = XLEN'(ISA_RESET); read_only = 1'b1; end
         ADDR_EPC:     rdata = epc_q;
         ADDR_SCRATCH: begin rdata = scratch_val; hit = SCRATCH_EN; end
         default:      hit = 1'b0;
      endcase
   end

   assign epc_out = epc_q;

   assert_status_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q & ~ST_MASK) == '0);
   assert_ret_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ret_en |=> (status_q[ST_PIE] && status_q[ST_PPRV_LO+1:ST_PPRV_LO] == 2'b00));
   assert_epc_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (epc_q & ~EPC_MASK) == '0);
endmodule

// File: rtl/mcsr_exec.sv
module mcsr_exec
   import mcsr_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          CAUSE_W       = 4,
   parameter logic [31:0] ISA_RESET     = 32'h4000_2000,
   parameter logic [31:0] STATUS_WMASK  = 32'h0000_1888,
   parameter int          EPC_ZERO_LSBS = 1,
   parameter bit          SCRATCH_EN    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [2:0]         funct3,
   input  logic [6:0]         funct7,
   input  logic [4:0]         rs2_field,
   input  logic [4:0]         rs1_field,
   input  logic [XLEN-1:0]    rs1_value,
   input  logic [11:0]        csr_addr,
   input  logic [4:0]         rd_idx,
   input  logic [1:0]         cur_priv,
   output logic               wb_en,
   output logic [4:0]         wb_rd,
   output logic [XLEN-1:0]    wb_data,
   output logic               redirect_valid,
   output logic [XLEN-1:0]    redirect_pc,
   output logic               illegal_instr,
   output logic [CAUSE_W-1:0] exc_cause
);
   if (CAUSE_W < 2) begin : g_chk_cause
      $error("mcsr_exec: CAUSE_W too small for the illegal cause code");
   end

   logic [XLEN-1:0] rdata, new_val, epc_val;
   logic hit, read_only, wr_req, op_known;
   logic is_csr, is_ret, csr_ill, ret_ill, csr_we, ret_en, csr_ok;

   mcsr_alu #(.XLEN(XLEN), .IMM_W(5)) alu_i (
      .funct3(funct3), .rs1_field(rs1_field), .rs1_value(rs1_value),
      .old_val(rdata), .new_val(new_val), .wr_req(wr_req), .op_known(op_known));

   mcsr_file #(.XLEN(XLEN), .ISA_RESET(ISA_RESET), .STATUS_WMASK(STATUS_WMASK),
               .EPC_ZERO_LSBS(EPC_ZERO_LSBS), .SCRATCH_EN(SCRATCH_EN)) file_i (
      .clk(clk), .rst_n(rst_n), .addr(csr_addr), .we(csr_we), .wdata(new_val),
      .ret_en(ret_en), .rdata(rdata), .hit(hit), .read_only(read_only),
      .epc_out(epc_val));

   always_comb begin
      is_csr  = instr_valid && op_known;
      is_ret  = instr_valid && funct3 == 3'b000 && funct7 == RET_FUNCT7 &&
                rs2_field == RET_RS2;
      csr_ill = is_csr && (!hit || (wr_req && read_only));
      ret_ill = is_ret && (cur_priv != PRIV_MACH);
      csr_ok  = is_csr && !csr_ill;
      csr_we  = csr_ok && wr_req;
      ret_en  = is_ret && !ret_ill;

      wb_en          = csr_ok && (rd_idx != '0);
      wb_rd          = wb_en ? rd_idx : '0;
      wb_data        = wb_en ? rdata : '0;
      redirect_valid = ret_en;
      redirect_pc    = ret_en ? epc_val : '0;
      illegal_instr  = csr_ill || ret_ill;
      exc_cause      = illegal_instr ? CAUSE_W'(CAUSE_ILL) : '0;
   end

   assert_illegal_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_instr |-> (!wb_en && !redirect_valid && !csr_we && !ret_en));
   assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> (!wb_en && !illegal_instr && !redirect_valid));
   assert_zero_src_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && funct3[1] && rs1_field == '0) |-> !csr_we);
   assert_ret_lowpriv_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (is_ret && cur_priv != PRIV_MACH) |-> (illegal_instr && !redirect_valid));
endmodule

// File: tb/mcsr_exec_tb.sv
module mcsr_exec_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [2:0]  funct3 = '0;
   logic [6:0]  funct7 = '0;
   logic [4:0]  rs2_field = '0, rs1_field = '0, rd_idx = '0;
   logic [31:0] rs1_value = '0;
   logic [11:0] csr_addr = '0;
   logic [1:0]  cur_priv = 2'b11;
   logic        wb_en, redirect_valid, illegal_instr;
   logic [4:0]  wb_rd;
   logic [31:0] wb_data, redirect_pc;
   logic [3:0]  exc_cause;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mcsr_exec dut_i (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .funct3(funct3),
      .funct7(funct7), .rs2_field(rs2_field), .rs1_field(rs1_field),
      .rs1_value(rs1_value), .csr_addr(csr_addr), .rd_idx(rd_idx),
      .cur_priv(cur_priv), .wb_en(wb_en), .wb_rd(wb_rd), .wb_data(wb_data),
      .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
      .illegal_instr(illegal_instr), .exc_cause(exc_cause));

   typedef struct packed {
      logic [2:0]  f3;
      logic [4:0]  rs1f;
      logic [31:0] rs1v;
      logic [11:0] addr;
      logic [4:0]  rd;
      logic        wben;
      logic [31:0] data;
      logic        ill;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [0:NV-1] = '{
      '{3'b001, 5'd5,  32'hDEADBEEF, 12'h340, 5'd1,  1'b1, 32'h0000_0000, 1'b0}, // R1 R2
      '{3'b010, 5'd6,  32'h0000_0010, 12'h340, 5'd2,  1'b1, 32'hDEADBEEF, 1'b0}, // R3 R5
      '{3'b011, 5'd7,  32'hFFFF_0000, 12'h340, 5'd3,  1'b1, 32'hDEADBEFF, 1'b0}, // R3
      '{3'b101, 5'h1F, 32'h0000_0000, 12'h340, 5'd4,  1'b1, 32'h0000_BEFF, 1'b0}, // R2
      '{3'b110, 5'd0,  32'h0000_0000, 12'h340, 5'd5,  1'b1, 32'h0000_001F, 1'b0}, // R8
      '{3'b111, 5'd3,  32'h0000_0000, 12'h340, 5'd6,  1'b1, 32'h0000_001F, 1'b0}, // R4
      '{3'b010, 5'd0,  32'hFFFF_FFFF, 12'h340, 5'd7,  1'b1, 32'h0000_001C, 1'b0}, // R8
      '{3'b001, 5'd1,  32'h0000_0000, 12'h340, 5'd0,  1'b0, 32'h0000_0000, 1'b0}, // R5 rd 0
      '{3'b010, 5'd0,  32'h0000_0000, 12'h340, 5'd8,  1'b1, 32'h0000_0000, 1'b0}, // R5
      '{3'b010, 5'd0,  32'h0000_0000, 12'h301, 5'd9,  1'b1, 32'h4000_2000, 1'b0}, // R1 R7
      '{3'b001, 5'd1,  32'h0000_0005, 12'h301, 5'd10, 1'b0, 32'h0000_0000, 1'b1}, // R7
      '{3'b101, 5'd2,  32'h0000_0000, 12'h301, 5'd10, 1'b0, 32'h0000_0000, 1'b1}, // R7
      '{3'b001, 5'd1,  32'h0000_0005, 12'h7C0, 5'd11, 1'b0, 32'h0000_0000, 1'b1}, // R6
      '{3'b110, 5'd0,  32'h0000_0000, 12'h7C0, 5'd11, 1'b0, 32'h0000_0000, 1'b1}, // R6
      '{3'b001, 5'd1,  32'hFFFF_FFFF, 12'h300, 5'd12, 1'b1, 32'h0000_0000, 1'b0}, // R1 R9
      '{3'b010, 5'd0,  32'h0000_0000, 12'h300, 5'd13, 1'b1, 32'h0000_1888, 1'b0}, // R9
      '{3'b001, 5'd1,  32'h0000_1235, 12'h341, 5'd14, 1'b1, 32'h0000_0000, 1'b0}, // R12
      '{3'b010, 5'd0,  32'h0000_0000, 12'h341, 5'd15, 1'b1, 32'h0000_1234, 1'b0}, // R12
      '{3'b111, 5'h1F, 32'h0000_0000, 12'h300, 5'd16, 1'b1, 32'h0000_1888, 1'b0}, // R4
      '{3'b010, 5'd0,  32'h0000_0000, 12'h300, 5'd17, 1'b1, 32'h0000_1880, 1'b0}  // R4
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [2:0] f3, input logic [4:0] r1f,
                        input logic [31:0] r1v, input logic [11:0] a, input logic [4:0] rd,
                        input logic [6:0] f7, input logic [4:0] r2, input logic [1:0] pr);
      @(negedge clk);
      instr_valid = v; funct3 = f3; rs1_field = r1f; rs1_value = r1v;
      csr_addr = a; rd_idx = rd; funct7 = f7; rs2_field = r2; cur_priv = pr;
      #5;
   endtask

   task automatic read_csr(input logic [11:0] a, input logic [31:0] exp, input string req);
      drive(1'b1, 3'b010, 5'd0, 32'h0, a, 5'd31, 7'd0, 5'd0, 2'b11);
      check(wb_en && wb_data == exp, req, wb_data, exp);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3 rst_n = 1'b1;
      #2;
      // R1 R13: idle outputs after reset
      check(!wb_en && !illegal_instr && !redirect_valid && exc_cause == 0, "R13 idle",
            {wb_en, illegal_instr, redirect_valid}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         drive(1'b1, VECS[i].f3, VECS[i].rs1f, VECS[i].rs1v, VECS[i].addr, VECS[i].rd,
               7'd0, 5'd0, 2'b11);
         check(wb_en == VECS[i].wben, $sformatf("R5 vec%0d wb_en", i), 32'(wb_en),
               32'(VECS[i].wben));
         check(wb_data == VECS[i].data, $sformatf("R2/R3 vec%0d wb_data", i), wb_data,
               VECS[i].data);
         check(illegal_instr == VECS[i].ill, $sformatf("R6 vec%0d illegal", i),
               32'(illegal_instr), 32'(VECS[i].ill));
         check(exc_cause == (VECS[i].ill ? 4'd2 : 4'd0), $sformatf("R6 vec%0d cause", i),
               32'(exc_cause), VECS[i].ill ? 32'd2 : 32'd0);
         if (VECS[i].wben)
            check(wb_rd == VECS[i].rd, $sformatf("R5 vec%0d wb_rd", i), 32'(wb_rd),
                  32'(VECS[i].rd));
      end

      // R13: invalid slot with a write pattern leaves scratch untouched
      drive(1'b0, 3'b001, 5'd1, 32'h0000_AAAA, 12'h340, 5'd3, 7'd0, 5'd0, 2'b11);
      check(!wb_en && !illegal_instr && !redirect_valid, "R13 invalid outputs",
            {wb_en, illegal_instr, redirect_valid}, 32'h0);
      read_csr(12'h340, 32'h0, "R13 scratch unchanged");
      // R13: funct3 000 with a non-return pattern
      drive(1'b1, 3'b000, 5'd0, 32'h0, 12'h000, 5'd0, 7'd0, 5'd0, 2'b11);
      check(!wb_en && !illegal_instr && !redirect_valid, "R13 other system",
            {wb_en, illegal_instr, redirect_valid}, 32'h0);

      // R10: trap return with previous-enable clear, previous-privilege machine
      drive(1'b1, 3'b001, 5'd1, 32'h0000_1808, 12'h300, 5'd0, 7'd0, 5'd0, 2'b11);
      drive(1'b1, 3'b000, 5'd0, 32'h0, 12'h302, 5'd0, 7'b0011000, 5'b00010, 2'b11);
      check(redirect_valid && !illegal_instr, "R10 redirect valid",
            {redirect_valid, illegal_instr}, 32'h2);
      check(redirect_pc == 32'h0000_1234, "R10 redirect pc", redirect_pc, 32'h0000_1234);
      read_csr(12'h300, 32'h0000_0080, "R10 status after return");

      // R11: trap return below machine level
      drive(1'b1, 3'b000, 5'd0, 32'h0, 12'h302, 5'd0, 7'b0011000, 5'b00010, 2'b01);
      check(illegal_instr && exc_cause == 4'd2 && !redirect_valid, "R11 low privilege",
            {illegal_instr, redirect_valid, exc_cause}, 32'h22);
      drive(1'b1, 3'b000, 5'd0, 32'h0, 12'h302, 5'd0, 7'b0011000, 5'b00010, 2'b00);
      check(illegal_instr && !redirect_valid && redirect_pc == 32'h0, "R11 user level",
            redirect_pc, 32'h0);
      read_csr(12'h300, 32'h0000_0080, "R11 status unchanged");

      // R1: reset in the middle of a run
      drive(1'b1, 3'b001, 5'd1, 32'h1234_5678, 12'h340, 5'd0, 7'd0, 5'd0, 2'b11);
      @(negedge clk);
      instr_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      read_csr(12'h340, 32'h0, "R1 scratch reset");
      read_csr(12'h300, 32'h0, "R1 status reset");
      read_csr(12'h341, 32'h0, "R1 epc reset");
      read_csr(12'h301, 32'h4000_2000, "R1 isa reset");

      @(negedge clk);
      instr_valid = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule